// File: doc/BRIEF.md
# Memory Atomic Operation Unit

This block performs a single indivisible read-modify-write on a small word-addressed memory that it holds internally. It serves the kind of command stream a command processor would issue. A request names a 4-bit operation, a word address and a span of one to four 32-bit words. It also carries two operand sets, A and B, each with one 32-bit word per lane, and a flag that asks for the prior memory contents to be returned. All operands arrive with the request, so nothing is fetched.

A request is taken on a valid/ready handshake. The unit then reads every targeted word in one cycle and computes the new value of each word in parallel lanes. It writes the results back in the next cycle. In the cycle after that write it raises a one-cycle response pulse, which carries the old data and an error bit. Arbitration among requesters, caching and address translation lie outside the block. The memory is organised as four word banks, so any aligned span is a single row access.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and every memory word reads as zero.
- R2: A request is accepted at a rising edge where req_valid and req_ready are both 1. req_ready is then 0 until the response has been given. resp_valid is a one-cycle pulse observed in the third cycle after the accepting edge, and req_ready is 1 again in the cycle after that pulse.
- R3: Code 1 stores memory AND A, code 2 stores memory OR A, code 3 stores memory XOR A, and code 4 stores A.
- R4: Code 7 stores memory + A. Code 8 stores memory - A. Code 9 stores A - memory. Every word wraps modulo 2^32 on its own, with no carry or borrow between words.
- R5: Code 5 stores memory + 1 and code 6 stores memory - 1, with modulo 2^32 wrap. Both ignore A and B.
- R6: Code 10 stores the two's-complement larger of memory and A, and code 11 stores the smaller. Code 12 stores the unsigned larger and code 13 the unsigned smaller.
- R7: Code 14 writes every word of B only when each targeted word equals the matching word of A. If any word differs, no word changes.
- R8: req_size holds the word count minus one. Lane i occupies bits 32*i+31 down to 32*i of the A, B and response data buses and maps to word address req_addr+i. Words outside the span are never written.
- R9: A two-word span needs an even address, and a three- or four-word span needs an address that is a multiple of four. A misaligned request writes nothing, sets resp_err and returns all-zero data.
- R10: Code 0 writes nothing and reports no error. Code 15 writes nothing and sets resp_err.
- R11: With req_ret at 1 and no error, the used lanes of resp_data carry the words as they were before the operation and the unused lanes are zero. With req_ret at 0, resp_data is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 4 | Operation code |
| req_addr | input | $clog2(DEPTH) | Word address of lane 0 |
| req_size | input | 2 | Word count minus one |
| req_ret | input | 1 | Return the old contents |
| req_opa | input | 4*DW | Operand set A, one word per lane |
| req_opb | input | 4*DW | Operand set B, one word per lane |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | 4*DW | Old contents of the targeted words |
| resp_err | output | 1 | Reserved code or misaligned span |

## Verification
The memory has no debug port. A lane-to-bank rotation fault, a wrong row, or a write enable that fires on a compare miss or on an unused lane therefore shows up only when a later request reads the affected word back. Every memory fault is visible at the ports one request later, which is four to five cycles. Code 0 with the return flag set serves as the read-back probe. A fault in the sequencing shows at once, as a response pulse outside the third cycle after acceptance or as req_ready rising early. An error-decode fault shows in the same response, as a stray resp_err or as non-zero data.

// File: rtl/atom_pkg.sv
package atom_pkg;

  localparam int LANES = 4;
  localparam int LW    = 2;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_MOVE = 4'd4,
    OP_INC  = 4'd5,
    OP_DEC  = 4'd6,
    OP_ADD  = 4'd7,
    OP_SUB  = 4'd8,
    OP_RSUB = 4'd9,
    OP_SMAX = 4'd10,
    OP_SMIN = 4'd11,
    OP_UMAX = 4'd12,
    OP_UMIN = 4'd13,
    OP_CMPX = 4'd14,
    OP_RSVD = 4'd15
  } atom_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/atom_lane_alu.sv
// One lane of the modify step: pure combinational word function.
module atom_lane_alu
  import atom_pkg::*;
#(
  parameter int DW = 32
) (
  input  atom_op_e        op,
  input  logic [DW-1:0]   mem,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  output logic [DW-1:0]   res,
  output logic            wr
);

  logic s_gt;
  logic u_gt;

  assign s_gt = $signed(mem) > $signed(opa);
  assign u_gt = mem > opa;

  always_comb begin
    res = mem;
    unique case (op)
      OP_AND:  res = mem & opa;
      OP_OR:   res = mem | opa;
      OP_XOR:  res = mem ^ opa;
      OP_MOVE: res = opa;
      OP_INC:  res = mem + DW'(1);
      OP_DEC:  res = mem - DW'(1);
      OP_ADD:  res = mem + opa;
      OP_SUB:  res = mem - opa;
      OP_RSUB: res = opa - mem;
      OP_SMAX: res = s_gt ? mem : opa;
      OP_SMIN: res = s_gt ? opa : mem;
      OP_UMAX: res = u_gt ? mem : opa;
      OP_UMIN: res = u_gt ? opa : mem;
      OP_CMPX: res = opb;
      default: res = mem;
    endcase
  end

  assign wr = (op != OP_NONE) && (op != OP_RSVD);

endmodule

// File: rtl/atom_bank.sv
// One word bank: combinational read, clock-enabled write, cleared at reset.
module atom_bank #(
  parameter int DW   = 32,
  parameter int ROWS = 16,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] cells_q [ROWS];

  assign rd_data = cells_q[row];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) cells_q[r] <= '0;
    end else if (wr_en) begin
      cells_q[row] <= wr_data;
    end
  end

endmodule

// File: rtl/atom_seq.sv
// Request sequencer: idle -> read -> write -> respond.
module atom_seq
  import atom_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic ld_cmd,
  output logic ld_old,
  output logic do_write,
  output logic resp_valid
);

  seq_state_e st_q;
  seq_state_e st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid) st_d = ST_READ;
      ST_READ:  st_d = ST_WRITE;
      ST_WRITE: st_d = ST_RESP;
      ST_RESP:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign ld_cmd     = req_valid && req_ready;
  assign ld_old     = (st_q == ST_READ);
  assign do_write   = (st_q == ST_WRITE);
  assign resp_valid = (st_q == ST_RESP);

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atom_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = LANES * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_ret,
  input  logic [BW-1:0] req_opa,
  input  logic [BW-1:0] req_opb,
  output logic          resp_valid,
  output logic [BW-1:0] resp_data,
  output logic          resp_err
);

  localparam int ROWS = DEPTH / LANES;
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;

  // sequencer strobes
  logic ld_cmd;
  logic ld_old;
  logic do_write;

  // captured command
  atom_op_e      op_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic          ret_q;
  logic          err_q;
  logic [BW-1:0] opa_q;
  logic [BW-1:0] opb_q;

  // datapath
  logic [LANES-1:0][DW-1:0] bank_rd;
  logic [LANES-1:0][DW-1:0] old_d;
  logic [LANES-1:0][DW-1:0] old_q;
  logic [LANES-1:0][DW-1:0] lane_res;
  logic [LANES-1:0]         lane_wr;
  logic [LANES-1:0]         lane_used;
  logic [LANES-1:0]         lane_eq;
  logic                     all_eq;
  logic                     cmp_block;
  logic [RW-1:0]            row_q;
  logic [LW-1:0]            base_q;

  logic          misalign_d;
  logic          err_d;
  logic [BW-1:0] resp_data_d;
  logic [BW-1:0] resp_data_q;
  logic          resp_err_q;

  atom_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .ld_cmd     (ld_cmd),
    .ld_old     (ld_old),
    .do_write   (do_write),
    .resp_valid (resp_valid)
  );

  // alignment and reserved-code decode at acceptance
  assign misalign_d = ((req_size == 2'd1) && req_addr[0]) ||
                      (req_size[1] && (req_addr[1:0] != 2'd0));
  assign err_d      = misalign_d || (req_op == 4'(OP_RSVD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      size_q <= '0;
      ret_q  <= 1'b0;
      err_q  <= 1'b0;
      opa_q  <= '0;
      opb_q  <= '0;
    end else if (ld_cmd) begin
      op_q   <= atom_op_e'(req_op);
      addr_q <= req_addr;
      size_q <= req_size;
      ret_q  <= req_ret;
      err_q  <= err_d;
      opa_q  <= req_opa;
      opb_q  <= req_opb;
    end
  end

  assign row_q  = RW'(addr_q >> LW);
  assign base_q = addr_q[LW-1:0];

  // per-lane read alignment, modify and compare
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] src_bank;
    assign src_bank     = base_q + LW'(g);
    assign old_d[g]     = bank_rd[src_bank];
    assign lane_used[g] = (LW'(g) <= size_q);
    assign lane_eq[g]   = !lane_used[g] || (old_q[g] == opa_q[g*DW +: DW]);

    atom_lane_alu #(.DW(DW)) u_alu (
      .op  (op_q),
      .mem (old_q[g]),
      .opa (opa_q[g*DW +: DW]),
      .opb (opb_q[g*DW +: DW]),
      .res (lane_res[g]),
      .wr  (lane_wr[g])
    );
  end

  assign all_eq    = &lane_eq;
  assign cmp_block = (op_q == OP_CMPX) && !all_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      old_q <= '0;
    else if (ld_old) old_q <= old_d;
  end

  // per-bank write-back with lane rotation
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [LW-1:0] lane_of;
    logic          bank_used;
    logic          bank_we;
    assign lane_of   = LW'(b) - base_q;
    assign bank_used = (lane_of <= size_q);
    assign bank_we   = do_write && !err_q && bank_used &&
                       lane_wr[lane_of] && !cmp_block;

    atom_bank #(.DW(DW), .ROWS(ROWS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_we),
      .row     (row_q),
      .wr_data (lane_res[lane_of]),
      .rd_data (bank_rd[b])
    );
  end

  // response capture at write-back
  always_comb begin
    resp_data_d = '0;
    for (int i = 0; i < LANES; i++) begin
      if (ret_q && !err_q && lane_used[i]) resp_data_d[i*DW +: DW] = old_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_data_q <= '0;
      resp_err_q  <= 1'b0;
    end else if (do_write) begin
      resp_data_q <= resp_data_d;
      resp_err_q  <= err_q;
    end
  end

  assign resp_data = resp_data_q;
  assign resp_err  = resp_err_q;

endmodule

// File: rtl/atomic_rmw_unit_chk.sv
module atomic_rmw_unit_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = 4 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [3:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          req_ret,
  input logic          resp_valid,
  input logic [BW-1:0] resp_data,
  input logic          resp_err
);

  logic mis_in;
  assign mis_in = ((req_size == 2'd1) && req_addr[0]) ||
                  (req_size[1] && (req_addr[1:0] != 2'd0));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R2
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready, 3));

  // R2
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && req_ready);

  // R10
  rsvd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && ($past(req_op, 3) == 4'd15) |-> resp_err);

  // R10
  none_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && ($past(req_op, 3) == 4'd0) && !$past(mis_in, 3) |-> !resp_err);

  // R9
  misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && $past(mis_in, 3) |-> resp_err && (resp_data == '0));

  // R11
  noret_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !$past(req_ret, 3) |-> (resp_data == '0));

endmodule

bind atomic_rmw_unit atomic_rmw_unit_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .req_ret    (req_ret),
  .resp_valid (resp_valid),
  .resp_data  (resp_data),
  .resp_err   (resp_err)
);

// File: tb/tb_atomic_rmw_unit.sv
`timescale 1ns/1ps
module tb_atomic_rmw_unit;

  localparam int DEPTH = 64;
  localparam int AW    = 6;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [3:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          req_ret;
  logic [127:0]  req_opa;
  logic [127:0]  req_opb;
  logic          resp_valid;
  logic [127:0]  resp_data;
  logic          resp_err;

  int checks;
  int errors;

  logic [31:0] model [DEPTH];
  int          last_lat;
  bit          last_busy_ok;
  bit          last_idle_ok;

  atomic_rmw_unit #(.DEPTH(DEPTH), .DW(32)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_ret    (req_ret),
    .req_opa    (req_opa),
    .req_opb    (req_opb),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .resp_err   (resp_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] word_fn(input logic [3:0] op, input logic [31:0] m,
                                          input logic [31:0] a, input logic [31:0] b);
    case (op)
      4'd1:  return m & a;
      4'd2:  return m | a;
      4'd3:  return m ^ a;
      4'd4:  return a;
      4'd5:  return m + 32'd1;
      4'd6:  return m - 32'd1;
      4'd7:  return m + a;
      4'd8:  return m - a;
      4'd9:  return a - m;
      4'd10: return ($signed(m) > $signed(a)) ? m : a;
      4'd11: return ($signed(m) < $signed(a)) ? m : a;
      4'd12: return (m > a) ? m : a;
      4'd13: return (m < a) ? m : a;
      4'd14: return b;
      default: return m;
    endcase
  endfunction

  // Issue one request, check response data and error against the model, update model.
  task automatic run_cmd(input logic [3:0] op, input int addr, input int size, input bit ret,
                         input logic [127:0] a, input logic [127:0] b, input string rq);
    int          words;
    bit          mis;
    bit          err;
    bit          cmp_ok;
    logic [31:0] old [4];
    logic [127:0] exp_d;
    logic [127:0] got_d;
    logic        got_e;
    words  = size + 1;
    mis    = (size == 1 && addr[0]) || (size >= 2 && addr[1:0] != 2'd0);
    err    = mis || (op == 4'd15);
    cmp_ok = 1'b1;
    exp_d  = '0;
    for (int i = 0; i < 4; i++) old[i] = '0;
    for (int i = 0; i < words; i++) begin
      old[i] = model[(addr + i) % DEPTH];
      if (old[i] != a[32*i +: 32]) cmp_ok = 1'b0;
      if (ret && !err) exp_d[32*i +: 32] = old[i];
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = AW'(addr);
    req_size  = 2'(size);
    req_ret   = ret;
    req_opa   = a;
    req_opb   = b;
    @(negedge clk);
    req_valid = 1'b0;
    last_lat  = 1;
    last_busy_ok = 1'b1;
    while (!resp_valid && last_lat < 10) begin
      if (req_ready) last_busy_ok = 1'b0;
      @(negedge clk);
      last_lat++;
    end
    got_d = resp_data;
    got_e = resp_err;
    @(negedge clk);
    last_idle_ok = req_ready && !resp_valid;
    chk({rq, " data"}, got_d, exp_d);
    chk({rq, " err"}, {127'd0, got_e}, {127'd0, err});
    if (!err) begin
      for (int i = 0; i < words; i++) begin
        if ((op >= 4'd1 && op <= 4'd13) || (op == 4'd14 && cmp_ok))
          model[(addr + i) % DEPTH] = word_fn(op, old[i], a[32*i +: 32], b[32*i +: 32]);
      end
    end
  endtask

  task automatic peek_all(input string rq);
    for (int r = 0; r < DEPTH / 4; r++) run_cmd(4'd0, r * 4, 3, 1'b1, '0, '0, rq);
  endtask

  task automatic t_reset;
    chk("R1 ready", {127'd0, req_ready}, {127'd0, 1'b1});
    chk("R1 resp_valid", {127'd0, resp_valid}, 128'd0);
    peek_all("R1 memory cleared");
  endtask

  task automatic t_handshake;
    run_cmd(4'd4, 0, 0, 1'b1, 128'h1234_5678, '0, "R2 move");
    chk("R2 latency", 128'(last_lat), 128'd3);
    chk("R2 busy", {127'd0, last_busy_ok}, {127'd0, 1'b1});
    chk("R2 idle after pulse", {127'd0, last_idle_ok}, {127'd0, 1'b1});
  endtask

  task automatic t_logic;
    run_cmd(4'd4, 4, 3, 1'b1, 128'hF0F0F0F0_0000FFFF_AAAAAAAA_12345678, '0, "R3 move");
    run_cmd(4'd1, 4, 3, 1'b1, 128'hFF00FF00_0F0F0F0F_FFFF0000_0000FFFF, '0, "R3 and");
    run_cmd(4'd2, 4, 3, 1'b1, 128'h00000001_F0000000_0000FFFF_11110000, '0, "R3 or");
    run_cmd(4'd3, 4, 3, 1'b1, 128'hFFFFFFFF_00000000_12345678_87654321, '0, "R3 xor");
    run_cmd(4'd0, 4, 3, 1'b1, '0, '0, "R3 readback");
  endtask

  task automatic t_arith;
    run_cmd(4'd4, 8, 1, 1'b0, {64'd0, 32'h0000_0005, 32'hFFFF_FFFF}, '0, "R4 move");
    run_cmd(4'd7, 8, 1, 1'b1, {64'd0, 32'd3, 32'd1}, '0, "R4 add no carry");
    chk("R4 lane1 after add", {96'd0, model[9]}, {96'd0, 32'd8});
    run_cmd(4'd8, 8, 1, 1'b1, {64'd0, 32'd10, 32'd1}, '0, "R4 sub");
    run_cmd(4'd9, 8, 1, 1'b1, {64'd0, 32'd10, 32'd1}, '0, "R4 rsub");
    run_cmd(4'd0, 8, 1, 1'b1, '0, '0, "R4 readback");
    run_cmd(4'd4, 10, 1, 1'b0, {64'd0, 32'd0, 32'hFFFF_FFFF}, '0, "R5 move");
    run_cmd(4'd5, 10, 0, 1'b1, {96'd0, 32'h7777_7777}, '1, "R5 inc wrap");
    run_cmd(4'd6, 11, 0, 1'b1, {96'd0, 32'h7777_7777}, '1, "R5 dec wrap");
    run_cmd(4'd0, 10, 1, 1'b1, '0, '0, "R5 readback");
  endtask

  task automatic t_minmax;
    logic [127:0] seed;
    seed = 128'hFFFF_FFFE_7FFF_FFFF_0000_0001_8000_0000;
    run_cmd(4'd4, 12, 3, 1'b0, seed, '0, "R6 move");
    run_cmd(4'd10, 12, 3, 1'b1, 128'h0000_0001_8000_0000_8000_0000_0000_0001, '0, "R6 smax");
    run_cmd(4'd4, 12, 3, 1'b0, seed, '0, "R6 move");
    run_cmd(4'd11, 12, 3, 1'b1, 128'h0000_0001_8000_0000_8000_0000_0000_0001, '0, "R6 smin");
    run_cmd(4'd4, 12, 3, 1'b0, seed, '0, "R6 move");
    run_cmd(4'd12, 12, 3, 1'b1, 128'h0000_0001_8000_0000_8000_0000_0000_0001, '0, "R6 umax");
    run_cmd(4'd4, 12, 3, 1'b0, seed, '0, "R6 move");
    run_cmd(4'd13, 12, 3, 1'b1, 128'h0000_0001_8000_0000_8000_0000_0000_0001, '0, "R6 umin");
    run_cmd(4'd0, 12, 3, 1'b1, '0, '0, "R6 readback");
  endtask

  task automatic t_compare;
    run_cmd(4'd4, 16, 1, 1'b0, {64'd0, 32'hBBBB_0002, 32'hAAAA_0001}, '0, "R7 move");
    run_cmd(4'd14, 16, 1, 1'b1, {64'd0, 32'hBBBB_0002, 32'hAAAA_0001},
            {64'd0, 32'hDDDD_0004, 32'hCCCC_0003}, "R7 cmp hit");
    run_cmd(4'd14, 16, 1, 1'b1, {64'd0, 32'h0000_0000, 32'hCCCC_0003},
            {64'd0, 32'h1111_1111, 32'h2222_2222}, "R7 cmp partial miss");
    run_cmd(4'd0, 16, 1, 1'b1, '0, '0, "R7 readback");
  endtask

  task automatic t_size;
    run_cmd(4'd4, 20, 3, 1'b0, 128'h4444_4444_3333_3333_2222_2222_1111_1111, '0, "R8 fill");
    run_cmd(4'd4, 20, 2, 1'b1, 128'hDEAD_DEAD_CCCC_CCCC_BBBB_BBBB_AAAA_AAAA, '0, "R8 three words");
    run_cmd(4'd4, 23, 0, 1'b1, {96'd0, 32'h5555_5555}, '0, "R8 single word");
    run_cmd(4'd0, 20, 3, 1'b1, '0, '0, "R8 readback");
  endtask

  task automatic t_align;
    run_cmd(4'd4, 25, 1, 1'b1, '1, '0, "R9 odd pair");
    run_cmd(4'd4, 26, 3, 1'b1, '1, '0, "R9 quad off");
    run_cmd(4'd4, 29, 2, 1'b1, '1, '0, "R9 triple off");
    run_cmd(4'd4, 31, 0, 1'b1, {96'd0, 32'h0BAD_F00D}, '0, "R9 single any");
    run_cmd(4'd4, 26, 1, 1'b1, {64'd0, 32'h6, 32'h5}, '0, "R9 even pair");
    run_cmd(4'd0, 24, 3, 1'b1, '0, '0, "R9 readback");
    run_cmd(4'd0, 28, 3, 1'b1, '0, '0, "R9 readback");
  endtask

  task automatic t_codes_ret;
    run_cmd(4'd15, 4, 3, 1'b1, '1, '1, "R10 reserved");
    run_cmd(4'd0, 4, 3, 1'b1, '1, '1, "R10 none");
    run_cmd(4'd4, 4, 3, 1'b0, 128'h9999_0000_8888_0000_7777_0000_6666_0000, '0, "R11 no return");
    run_cmd(4'd0, 4, 1, 1'b1, '0, '0, "R11 unused lanes zero");
  endtask

  task automatic t_mixed;
    logic [31:0] lf;
    lf = 32'hACE1_2345;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      run_cmd(lf[3:0], int'(lf[9:4]), int'(lf[11:10]), lf[12],
              {lf, ~lf, lf ^ 32'h5A5A_5A5A, lf + 32'd7},
              {~lf, lf, lf - 32'd3, lf ^ 32'hFFFF_0000}, "R8 mixed");
    end
    peek_all("R8 final memory");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_op    = '0;
    req_addr  = '0;
    req_size  = '0;
    req_ret   = 1'b0;
    req_opa   = '0;
    req_opb   = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_handshake();
    t_logic();
    t_arith();
    t_minmax();
    t_compare();
    t_size();
    t_align();
    t_codes_ret();
    t_mixed();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule